// File: doc/BRIEF.md
# Reloadable Table-Lookup Constant Multiplier

This block forms the unsigned product of a variable input word and a constant that changes only rarely, such as when a transform key is replaced. No multiplier sits on the data path. The input is cut into 4-bit slices, and each slice addresses its own 16-entry table. Entry n of a table holds n times the constant. The partial products read from the tables are moved up by four bits for each slice position and added together. A two-stage pipeline accepts one input per cycle.

A new constant is installed by pulsing a load strobe with the constant on a side input. A sequencer then rebuilds every table in 16 cycles, writing one entry per cycle by adding the constant to the entry written before it. While the rebuild runs, the block reports busy, drops its inputs and keeps its result-valid flag low. A result computed from a half-written table is therefore never presented.

Top module: `lutmul_rcm`

## Requirements
- R1: After reset, busy and out_valid are low and the stored constant is zero, so any accepted input yields a product of 0.
- R2: An input presented with in_valid high while busy is low produces out_valid high exactly two clock edges later, with out_prod equal to the unsigned product of in_data and the current constant, DATA_W+COEF_W bits wide and never truncated. One input can be accepted every cycle.
- R3: A load strobe sampled while idle raises busy at the next edge. Busy then stays high for exactly 16 cycles, during which table entries 0 to 15 are written in ascending order, one per cycle.
- R4: While busy is high, out_valid is low. An input presented while busy is high, or in the cycle of an accepted load strobe, produces no result.
- R5: A load strobe sampled while busy is high is ignored. The rebuild in progress keeps the constant it started with and ends on its normal schedule.
- R6: A constant of 0 gives a product of 0 for every input. The all-ones constant gives the exact full-width product, including the largest value (2^DATA_W-1)*(2^COEF_W-1).
- R7: Slice s of the input (bits 4s+3 down to 4s) is weighted by 2^(4s). An input whose only nonzero slice is the upper one yields the slice value times the constant times 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_stb | input | 1 | Starts a table rebuild with load_coef (ignored while busy) |
| load_coef | input | COEF_W | New constant value |
| busy | output | 1 | High while tables are being rewritten |
| in_valid | input | 1 | Input word is valid |
| in_data | input | DATA_W | Unsigned input word |
| out_valid | output | 1 | out_prod is valid |
| out_prod | output | DATA_W+COEF_W | Unsigned product |

## Verification
A single corrupted table entry shows up only for inputs whose slice selects that entry. For this reason every constant is checked against all 256 input words, and any bad entry surfaces at out_prod two cycles after the first word that reaches it. A sequencer that writes the wrong stride or stops early leaves the high-index entries wrong. That appears as soon as the sweep reaches an input with a large slice value, and it also shows directly as a busy window that is not exactly 16 cycles long. Broken valid gating appears as a spurious out_valid during the rebuild window, or as a missing one just after it.

// File: rtl/lutmul_pkg.sv
package lutmul_pkg;

    localparam int SLICE_W   = 4;
    localparam int TBL_DEPTH = 1 << SLICE_W;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_RUN  = 1'b1
    } fill_state_e;

    typedef struct packed {
        logic               en;
        logic [SLICE_W-1:0] addr;
    } tbl_wr_ctl_t;

    function automatic int slice_count(input int width);
        return (width + SLICE_W - 1) / SLICE_W;
    endfunction

endpackage

// File: rtl/lutmul_reload_seq.sv
module lutmul_reload_seq
    import lutmul_pkg::*;
#(
    parameter int COEF_W = 12,
    localparam int PP_W  = COEF_W + SLICE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_stb,
    input  logic [COEF_W-1:0] load_coef,
    output logic              busy,
    output tbl_wr_ctl_t       wr_ctl,
    output logic [PP_W-1:0]   wr_data
);

    fill_state_e         state;
    logic [SLICE_W-1:0]  idx;
    logic [PP_W-1:0]     acc;
    logic [COEF_W-1:0]   coef_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FILL_IDLE;
            idx    <= '0;
            acc    <= '0;
            coef_q <= '0;
        end else begin
            case (state)
                FILL_IDLE: begin
                    if (load_stb) begin
                        state  <= FILL_RUN;
                        idx    <= '0;
                        acc    <= '0;
                        coef_q <= load_coef;
                    end
                end
                FILL_RUN: begin
                    idx <= idx + 1'b1;
                    acc <= acc + PP_W'(coef_q);
                    if (idx == SLICE_W'(TBL_DEPTH - 1)) begin
                        state <= FILL_IDLE;
                    end
                end
                default: state <= FILL_IDLE;
            endcase
        end
    end

    assign busy        = (state == FILL_RUN);
    assign wr_ctl.en   = (state == FILL_RUN);
    assign wr_ctl.addr = idx;
    assign wr_data     = acc;

    // R3: a rebuild only ever starts from a strobe
    assert_busy_from_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(load_stb));

    // R3: the last entry write ends the busy window
    assert_fill_ends_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl.en && wr_ctl.addr == SLICE_W'(TBL_DEPTH - 1)) |=> !busy);

    // R5: a strobe during a rebuild neither stops nor restarts it
    assert_strobe_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && load_stb && wr_ctl.addr != SLICE_W'(TBL_DEPTH - 1))
            |=> (busy && wr_ctl.addr == $past(wr_ctl.addr) + 1'b1));

endmodule

// File: rtl/lutmul_slice_table.sv
module lutmul_slice_table
    import lutmul_pkg::*;
#(
    parameter int ENTRY_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  tbl_wr_ctl_t        wr_ctl,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [SLICE_W-1:0] rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);

    logic [ENTRY_W-1:0] mem [TBL_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TBL_DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_ctl.en) begin
            mem[wr_ctl.addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // R6: entry 0 is the product of zero and stays zero for every constant
    assert_entry_zero_R6: assert property (@(posedge clk) disable iff (rst)
        mem[0] == '0);

endmodule

// File: rtl/lutmul_combine.sv
module lutmul_combine
    import lutmul_pkg::*;
#(
    parameter int NSLICE = 2,
    parameter int PP_W   = 16,
    parameter int PROD_W = 20
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pp_valid,
    input  logic [NSLICE*PP_W-1:0] pp_flat,
    input  logic                   hold_off,
    output logic                   out_valid,
    output logic [PROD_W-1:0]      out_prod
);

    logic [NSLICE*PP_W-1:0] pp_q;
    logic                   v1;
    logic                   v2;
    logic [PROD_W-1:0]      sum_d;
    logic [PROD_W-1:0]      sum_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pp_q <= '0;
            v1   <= 1'b0;
        end else begin
            pp_q <= pp_flat;
            v1   <= pp_valid;
        end
    end

    always_comb begin
        sum_d = '0;
        for (int s = 0; s < NSLICE; s++) begin
            sum_d = sum_d + (PROD_W'(pp_q[s*PP_W +: PP_W]) << (SLICE_W * s));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            v2    <= 1'b0;
        end else begin
            sum_q <= sum_d;
            v2    <= v1;
        end
    end

    assign out_valid = v2 && !hold_off;
    assign out_prod  = sum_q;

    // R2: a result leaves the second stage only after the first held it
    assert_stage_order_R2: assert property (@(posedge clk) disable iff (rst)
        v2 |-> $past(v1));

endmodule

// File: rtl/lutmul_rcm.sv
module lutmul_rcm
    import lutmul_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COEF_W = 12,
    localparam int PROD_W = DATA_W + COEF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_stb,
    input  logic [COEF_W-1:0] load_coef,
    output logic              busy,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [PROD_W-1:0] out_prod
);

    localparam int NSLICE = slice_count(DATA_W);
    localparam int PAD_W  = NSLICE * SLICE_W;
    localparam int PP_W   = COEF_W + SLICE_W;

    tbl_wr_ctl_t            wr_ctl;
    logic [PP_W-1:0]        wr_data;
    logic [PAD_W-1:0]       data_pad;
    logic [NSLICE*PP_W-1:0] pp_flat;
    logic                   accept;

    lutmul_reload_seq #(.COEF_W(COEF_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load_stb  (load_stb),
        .load_coef (load_coef),
        .busy      (busy),
        .wr_ctl    (wr_ctl),
        .wr_data   (wr_data)
    );

    assign data_pad = PAD_W'(in_data);
    assign accept   = in_valid && !busy;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        lutmul_slice_table #(.ENTRY_W(PP_W)) u_tbl (
            .clk     (clk),
            .rst     (rst),
            .wr_ctl  (wr_ctl),
            .wr_data (wr_data),
            .rd_addr (data_pad[s*SLICE_W +: SLICE_W]),
            .rd_data (pp_flat[s*PP_W +: PP_W])
        );
    end

    lutmul_combine #(
        .NSLICE (NSLICE),
        .PP_W   (PP_W),
        .PROD_W (PROD_W)
    ) u_comb (
        .clk       (clk),
        .rst       (rst),
        .pp_valid  (accept),
        .pp_flat   (pp_flat),
        .hold_off  (busy),
        .out_valid (out_valid),
        .out_prod  (out_prod)
    );

    // R4: no result is reported during a rebuild
    assert_quiet_busy_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> !out_valid);

    // R2: every result traces back to an input accepted two edges earlier
    assert_valid_origin_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid, 2) && !$past(busy, 2)));

endmodule

// File: tb/tb_lutmul_rcm.sv
module tb_lutmul_rcm;

    localparam int CLK_P  = 10;
    localparam int DATA_W = 8;
    localparam int COEF_W = 12;
    localparam int PROD_W = DATA_W + COEF_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load_stb = 1'b0;
    logic [COEF_W-1:0] load_coef = '0;
    logic              busy;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [PROD_W-1:0] out_prod;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic              h1_v, h2_v;
    logic [PROD_W-1:0] h1_p, h2_p;
    string             h1_tag, h2_tag;

    always #(CLK_P/2) clk = ~clk;

    lutmul_rcm #(.DATA_W(DATA_W), .COEF_W(COEF_W)) dut (
        .clk(clk), .rst(rst), .load_stb(load_stb), .load_coef(load_coef),
        .busy(busy), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_prod(out_prod)
    );

    function automatic logic [PROD_W-1:0] ref_mul(input logic [DATA_W-1:0] d,
                                                  input logic [COEF_W-1:0] c);
        return PROD_W'(d) * PROD_W'(c);
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Called at a negedge: check the result of the input applied two steps ago,
    // then apply a new input and advance to the next negedge.
    task automatic step(input logic v, input logic [DATA_W-1:0] d,
                        input logic ev, input logic [PROD_W-1:0] ep, input string tag);
        compared++;
        if (out_valid !== h2_v || (h2_v && out_prod !== h2_p)) begin
            mismatched++;
            $display("FAIL %s: actual valid=%0b prod=%0d expected valid=%0b prod=%0d",
                     h2_tag, out_valid, out_prod, h2_v, h2_p);
        end
        h2_v = h1_v; h2_p = h1_p; h2_tag = h1_tag;
        h1_v = ev;   h1_p = ep;   h1_tag = tag;
        in_valid = v;
        in_data  = d;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, "idle");
    endtask

    // Load a constant; inputs are driven during the busy window and must be dropped (R4).
    // Optionally pulse a second strobe mid-rebuild (R5).
    task automatic do_load(input logic [COEF_W-1:0] c, input bit stray,
                           input logic [COEF_W-1:0] c2);
        idle(2);
        load_stb  = 1'b1;
        load_coef = c;
        step(1'b1, 8'hA7, 1'b0, '0, "R4 strobe-cycle input");
        load_stb  = 1'b0;
        for (int j = 1; j <= 16; j++) begin
            check_bit("R3 busy inside window", busy, 1'b1);
            if (stray && j == 5) begin
                load_stb  = 1'b1;
                load_coef = c2;
            end
            step(1'b1, DATA_W'(j * 13), 1'b0, '0, "R4 input during busy");
            load_stb = 1'b0;
        end
        check_bit("R3 busy after 16 cycles", busy, 1'b0);
    endtask

    task automatic sweep(input logic [COEF_W-1:0] c, input string tag);
        for (int i = 0; i < (1 << DATA_W); i++) begin
            step(1'b1, DATA_W'(i), 1'b1, ref_mul(DATA_W'(i), c), tag);
        end
        idle(2);
    endtask

    initial begin
        logic [COEF_W-1:0] c;
        h1_v = 0; h2_v = 0; h1_p = '0; h2_p = '0; h1_tag = "init"; h2_tag = "init";
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check_bit("R1 busy after reset", busy, 1'b0);
        check_bit("R1 out_valid after reset", out_valid, 1'b0);
        step(1'b1, 8'hFF, 1'b1, '0, "R1 zero constant after reset");
        step(1'b1, 8'h5A, 1'b1, '0, "R1 zero constant after reset");
        idle(2);

        // R6: all-ones constant, full sweep incl. max product
        do_load({COEF_W{1'b1}}, 1'b0, '0);
        sweep({COEF_W{1'b1}}, "R6 all-ones constant");
        // R6: zero constant
        do_load('0, 1'b0, '0);
        sweep('0, "R6 zero constant");
        // R2: directed and random constants
        do_load(12'h001, 1'b0, '0);
        sweep(12'h001, "R2 unit constant");
        do_load(12'hA5C, 1'b0, '0);
        sweep(12'hA5C, "R2 constant A5C");
        // R7: upper slice only
        for (int u = 1; u < 16; u++) begin
            step(1'b1, DATA_W'(u << 4), 1'b1, PROD_W'(u) * PROD_W'(12'hA5C) * 16,
                 "R7 upper slice weight");
        end
        idle(2);
        // R5: stray strobe during rebuild is ignored
        do_load(12'h3B1, 1'b1, 12'hF0F);
        sweep(12'h3B1, "R5 constant kept after stray strobe");
        // R2: random constants with random gaps
        for (int k = 0; k < 3; k++) begin
            c = COEF_W'($urandom);
            do_load(c, 1'b0, '0);
            sweep(c, "R2 random constant sweep");
            for (int n = 0; n < 200; n++) begin
                logic v;
                logic [DATA_W-1:0] d;
                v = 1'($urandom);
                d = DATA_W'($urandom);
                step(v, d, v, ref_mul(d, c), "R2 random stream");
            end
            idle(2);
        end
        idle(2);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule